// File: doc/BRIEF.md
# Direct Two-Symbol Error Locator and Evaluator

This block finishes the decoding of a 516-symbol Reed-Solomon block (10-bit symbols, minimum distance 5) once its four syndromes are known. A pulse on `start` captures the four syndromes into internal registers. The syndrome generator upstream can then begin on the next block while this block works out whether the captured syndromes describe no error, one symbol error or two symbol errors. For each error it reports the position and the 10-bit error value. When neither hypothesis fits, it raises an uncorrectable flag instead. Applying the corrections to the buffered data is left to the host.

The decoder uses no field inversion and no iterative locator-polynomial algorithm. A single general multiplier is shared over four set-up cycles to form the quadratic's coefficients. Constant multipliers then step through every candidate position, one per clock, and evaluate the single-error relation or the two-error quadratic. An error value is found by stepping a constant-multiplied product until it equals a target, so no division is needed. Apart from these, only squarers and XOR sums are used.

Top module: `twoerr_locator`

## Requirements
- R1: Arithmetic is in GF(2^10) with field polynomial x^10+x^3+1 and alpha = x. Syndrome j (j = 0..3) equals the sum over errors of e·alpha^(p·j), where e is the error value and p is the position. When `start` is sampled with all four syndromes zero, `done` is high in the very next cycle with `err_cnt` = 0, `eed` = 0 and `irq` low, and `busy` never rises.
- R2: When the syndromes match one error (S1² = S0·S2, S2² = S1·S3, S0 ≠ 0) at a position p in 0..515, the block reports `err_cnt` = 1, `loc1` = p and `mag1` = S0, with `loc2` and `mag2` both zero.
- R3: When the syndromes match two errors at distinct positions in 0..515, the block reports `err_cnt` = 2 with `loc1` < `loc2`. `mag1` is the value at `loc1` and `mag2` is the value at `loc2`, and both are nonzero.
- R4: When the syndromes fit neither hypothesis, the block reports `eed` = 1 and `err_cnt` = 0, with all locations and values zero. A nonzero syndrome set whose two-error quadratic has A = S0·S2+S1² = 0 and which fails the single-error test falls into this case.
- R5: Only positions 0..515 are accepted. A single-error match or a quadratic root that lies beyond position 515 does not count as a location, and the result is then `eed` = 1.
- R6: The syndromes are captured at the accepted `start`. Changes on the syndrome inputs while `busy` is high do not affect the result, and a `start` while `busy` is high is ignored.
- R7: For nonzero syndromes, `busy` is high from the cycle after the accepted `start` until `done`. `done` is a one-cycle pulse during which `busy` is low.
- R8: `irq` pulses together with `done` for every decode of nonzero syndromes, and never for all-zero syndromes.
- R9: Counting the edge that samples `start` as the first, `done` is seen within 1548 clock cycles at the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (the doubled internal step clock) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture syndromes and begin decoding when idle |
| syn0 | input | 10 | Syndrome S0 |
| syn1 | input | 10 | Syndrome S1 |
| syn2 | input | 10 | Syndrome S2 |
| syn3 | input | 10 | Syndrome S3 |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Result-ready interrupt pulse for nonzero syndromes |
| err_cnt | output | 2 | Number of located errors: 0, 1 or 2 |
| eed | output | 1 | Detected but uncorrectable error |
| loc1 | output | 10 | Lower error position |
| loc2 | output | 10 | Higher error position |
| mag1 | output | 10 | Error value at loc1 |
| mag2 | output | 10 | Error value at loc2 |

## Verification
Syndromes are built in the bench from injected errors: none, one or two errors at random positions with random nonzero values, and three random errors. Syndromes from one or two injected errors must give back exactly the injected positions and values, which separates the single-error path from the quadratic-root path and tests how roots are ordered. The three-error sets and hand-made syndromes (only S3 nonzero, a single error placed at position 700, errors at the ends 0 and 515, two equal values so that S0 is zero) exercise the uncorrectable verdict, the position bound and the end stops of the scan. A disturbed run changes the syndrome inputs and pulses `start` mid-decode, which separates captured syndromes from live ones.

// File: rtl/twoerr_pkg.sv
package twoerr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROD,
    ST_CLASS,
    ST_SCAN,
    ST_NUM,
    ST_MAG,
    ST_FIN
  } dec_state_t;

  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_ONE  = 2'd1,
    CNT_TWO  = 2'd2
  } err_cnt_t;

endpackage

// File: rtl/gf_gmul.sv
module gf_gmul #(
  parameter int              W    = 10,
  parameter logic [W-1:0]    POLY = 10'h009
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  // Horner-style shift-and-add product, reduced by POLY each step
  always_comb begin
    logic [W-1:0] acc;
    acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = {acc[W-2:0], 1'b0} ^ (acc[W-1] ? POLY : '0);
      if (b[i]) acc = acc ^ a;
    end
    p = acc;
  end
endmodule

// File: rtl/gf_cmul.sv
module gf_cmul #(
  parameter int           W     = 10,
  parameter logic [W-1:0] POLY  = 10'h009,
  parameter int           SHIFT = 1
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] p
);
  // Multiply by alpha^SHIFT as a chain of single-bit shifts
  logic [W-1:0] stage [SHIFT+1];
  assign stage[0] = a;
  for (genvar g = 0; g < SHIFT; g++) begin : g_step
    assign stage[g+1] = {stage[g][W-2:0], 1'b0} ^ (stage[g][W-1] ? POLY : '0);
  end
  assign p = stage[SHIFT];
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int           W    = 10,
  parameter logic [W-1:0] POLY = 10'h009
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] p
);
  // Squaring is linear: sum of alpha^(2i) over set bits
  always_comb begin
    logic [W-1:0] term;
    logic [W-1:0] acc;
    term = {{(W-1){1'b0}}, 1'b1};
    acc  = '0;
    for (int i = 0; i < W; i++) begin
      if (a[i]) acc = acc ^ term;
      term = {term[W-2:0], 1'b0} ^ (term[W-1] ? POLY : '0);
      term = {term[W-2:0], 1'b0} ^ (term[W-1] ? POLY : '0);
    end
    p = acc;
  end
endmodule

// File: rtl/twoerr_locator.sv
module twoerr_locator
  import twoerr_pkg::*;
#(
  parameter int               SYM_W = 10,
  parameter logic [SYM_W-1:0] POLY  = 10'h009,
  parameter int               NPOS  = 516,
  parameter int               POS_W = $clog2(NPOS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SYM_W-1:0] syn0,
  input  logic [SYM_W-1:0] syn1,
  input  logic [SYM_W-1:0] syn2,
  input  logic [SYM_W-1:0] syn3,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic [1:0]       err_cnt,
  output logic             eed,
  output logic [POS_W-1:0] loc1,
  output logic [POS_W-1:0] loc2,
  output logic [SYM_W-1:0] mag1,
  output logic [SYM_W-1:0] mag2
);

  localparam logic [POS_W-1:0] K_LAST   = POS_W'(NPOS - 1);
  localparam logic [SYM_W-1:0] M_LAST   = SYM_W'((1 << SYM_W) - 2);
  localparam logic [SYM_W-1:0] SYM_ONE  = SYM_W'(1);
  localparam int               NPROD    = 4;

  dec_state_t       st;
  logic [SYM_W-1:0] s_q   [4];
  logic [SYM_W-1:0] p_q   [NPROD];
  logic [1:0]       pidx;
  logic             dbl_q;
  logic             one_root_q;
  logic [SYM_W-1:0] run_q, t2_q, c_q, xk_q, x1_q, x2_q, n_q;
  logic [POS_W-1:0] k_q, l1_q, l2_q;
  logic [SYM_W-1:0] m_q, e1_q, e2_q;
  logic [1:0]       cnt_q;
  logic             eed_q;

  // ---------------- arithmetic datapath ----------------
  logic [SYM_W-1:0] mul_a, mul_b, mul_p;
  logic [SYM_W-1:0] sq_v [2];
  logic [SYM_W-1:0] run_nx, t2_nx, xk_nx;
  logic [SYM_W-1:0] coef_a, coef_b, coef_c;
  logic [SYM_W-1:0] poly_val, num_v;
  logic             syn_zero, poly_zero, k_end;

  // single shared general multiplier
  always_comb begin
    if (st == ST_NUM) begin
      mul_a = s_q[0];
      mul_b = x2_q;
    end else begin
      unique case (pidx)
        2'd0:    begin mul_a = s_q[0]; mul_b = s_q[2]; end
        2'd1:    begin mul_a = s_q[1]; mul_b = s_q[3]; end
        2'd2:    begin mul_a = s_q[0]; mul_b = s_q[3]; end
        default: begin mul_a = s_q[1]; mul_b = s_q[2]; end
      endcase
    end
  end

  gf_gmul #(.W(SYM_W), .POLY(POLY)) u_gmul (.a(mul_a), .b(mul_b), .p(mul_p));

  for (genvar g = 0; g < 2; g++) begin : g_sq
    gf_sqr #(.W(SYM_W), .POLY(POLY)) u_sq (.a(s_q[g+1]), .p(sq_v[g]));
  end

  gf_cmul #(.W(SYM_W), .POLY(POLY), .SHIFT(1)) u_step_run (.a(run_q), .p(run_nx));
  gf_cmul #(.W(SYM_W), .POLY(POLY), .SHIFT(2)) u_step_t2  (.a(t2_q),  .p(t2_nx));
  gf_cmul #(.W(SYM_W), .POLY(POLY), .SHIFT(1)) u_step_x   (.a(xk_q),  .p(xk_nx));

  // quadratic coefficients A, B, C from the stored products
  assign coef_a    = p_q[0] ^ sq_v[0];
  assign coef_b    = p_q[2] ^ p_q[3];
  assign coef_c    = p_q[1] ^ sq_v[1];
  assign poly_val  = t2_q ^ run_q ^ c_q;
  assign poly_zero = (poly_val == '0);
  assign k_end     = (k_q == K_LAST);
  assign num_v     = mul_p ^ s_q[1];
  assign syn_zero  = ~|{syn0, syn1, syn2, syn3};

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
      err_cnt    <= CNT_NONE;
      eed        <= 1'b0;
      loc1       <= '0;
      loc2       <= '0;
      mag1       <= '0;
      mag2       <= '0;
      pidx       <= '0;
      dbl_q      <= 1'b0;
      one_root_q <= 1'b0;
      run_q      <= '0;
      t2_q       <= '0;
      c_q        <= '0;
      xk_q       <= '0;
      x1_q       <= '0;
      x2_q       <= '0;
      n_q        <= '0;
      k_q        <= '0;
      m_q        <= '0;
      l1_q       <= '0;
      l2_q       <= '0;
      e1_q       <= '0;
      e2_q       <= '0;
      cnt_q      <= CNT_NONE;
      eed_q      <= 1'b0;
      for (int i = 0; i < 4; i++) s_q[i] <= '0;
      for (int i = 0; i < NPROD; i++) p_q[i] <= '0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            s_q[0]  <= syn0;
            s_q[1]  <= syn1;
            s_q[2]  <= syn2;
            s_q[3]  <= syn3;
            err_cnt <= CNT_NONE;
            eed     <= 1'b0;
            loc1    <= '0;
            loc2    <= '0;
            mag1    <= '0;
            mag2    <= '0;
            if (syn_zero) begin
              done <= 1'b1;
            end else begin
              busy <= 1'b1;
              pidx <= '0;
              st   <= ST_PROD;
            end
          end
        end

        ST_PROD: begin
          p_q[pidx] <= mul_p;
          pidx      <= pidx + 2'd1;
          if (pidx == 2'd3) st <= ST_CLASS;
        end

        ST_CLASS: begin
          k_q        <= '0;
          xk_q       <= SYM_ONE;
          one_root_q <= 1'b0;
          if (coef_a == '0 && coef_c == '0 && s_q[0] != '0) begin
            dbl_q <= 1'b0;
            run_q <= s_q[0];
            st    <= ST_SCAN;
          end else if (coef_a != '0) begin
            dbl_q <= 1'b1;
            t2_q  <= coef_a;
            run_q <= coef_b;
            c_q   <= coef_c;
            st    <= ST_SCAN;
          end else begin
            cnt_q <= CNT_NONE;
            eed_q <= 1'b1;
            st    <= ST_FIN;
          end
        end

        ST_SCAN: begin
          if (!dbl_q) begin
            if (run_q == s_q[1]) begin
              l1_q  <= k_q;
              e1_q  <= s_q[0];
              cnt_q <= CNT_ONE;
              eed_q <= 1'b0;
              st    <= ST_FIN;
            end else if (k_end) begin
              cnt_q <= CNT_NONE;
              eed_q <= 1'b1;
              st    <= ST_FIN;
            end else begin
              run_q <= run_nx;
              k_q   <= k_q + 1'b1;
            end
          end else begin
            if (poly_zero && one_root_q) begin
              l2_q <= k_q;
              x2_q <= xk_q;
              st   <= ST_NUM;
            end else begin
              if (poly_zero) begin
                l1_q       <= k_q;
                x1_q       <= xk_q;
                one_root_q <= 1'b1;
              end
              if (k_end) begin
                cnt_q <= CNT_NONE;
                eed_q <= 1'b1;
                st    <= ST_FIN;
              end else begin
                t2_q  <= t2_nx;
                run_q <= run_nx;
                xk_q  <= xk_nx;
                k_q   <= k_q + 1'b1;
              end
            end
          end
        end

        ST_NUM: begin
          // E1*(X1+X2) must equal S0*X2 + S1
          n_q   <= num_v;
          run_q <= x1_q ^ x2_q;
          xk_q  <= SYM_ONE;
          m_q   <= '0;
          if (num_v == '0) begin
            cnt_q <= CNT_NONE;
            eed_q <= 1'b1;
            st    <= ST_FIN;
          end else begin
            st <= ST_MAG;
          end
        end

        ST_MAG: begin
          if (run_q == n_q) begin
            if ((s_q[0] ^ xk_q) == '0) begin
              cnt_q <= CNT_NONE;
              eed_q <= 1'b1;
            end else begin
              e1_q  <= xk_q;
              e2_q  <= s_q[0] ^ xk_q;
              cnt_q <= CNT_TWO;
              eed_q <= 1'b0;
            end
            st <= ST_FIN;
          end else if (m_q == M_LAST) begin
            cnt_q <= CNT_NONE;
            eed_q <= 1'b1;
            st    <= ST_FIN;
          end else begin
            run_q <= run_nx;
            xk_q  <= xk_nx;
            m_q   <= m_q + 1'b1;
          end
        end

        ST_FIN: begin
          busy    <= 1'b0;
          done    <= 1'b1;
          irq     <= 1'b1;
          err_cnt <= cnt_q;
          eed     <= eed_q;
          if (!eed_q) begin
            loc1 <= l1_q;
            mag1 <= e1_q;
            loc2 <= (cnt_q == CNT_TWO) ? l2_q : '0;
            mag2 <= (cnt_q == CNT_TWO) ? e2_q : '0;
          end
          st <= ST_IDLE;
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twoerr_locator_chk.sv
module twoerr_locator_chk #(
  parameter int SYM_W = 10,
  parameter int NPOS  = 516,
  parameter int POS_W = $clog2(NPOS)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [SYM_W-1:0] syn0,
  input logic [SYM_W-1:0] syn1,
  input logic [SYM_W-1:0] syn2,
  input logic [SYM_W-1:0] syn3,
  input logic             busy,
  input logic             done,
  input logic             irq,
  input logic [1:0]       err_cnt,
  input logic             eed,
  input logic [POS_W-1:0] loc1,
  input logic [POS_W-1:0] loc2,
  input logic [SYM_W-1:0] mag1,
  input logic [SYM_W-1:0] mag2
);
  localparam int BUSY_MAX = NPOS + (1 << SYM_W) + 8;
  localparam logic [POS_W-1:0] P_LAST = POS_W'(NPOS - 1);

  logic [31:0] busy_cyc;
  logic        syn_nz;
  assign syn_nz = |{syn0, syn1, syn2, syn3};

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cyc <= '0;
    else              busy_cyc <= busy_cyc + 32'd1;
  end

  assert_zero_fast_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !syn_nz) |=> (done && !irq && !busy && err_cnt == 2'd0 && !eed));

  assert_single_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (done && err_cnt == 2'd1) |-> (loc2 == '0 && mag2 == '0 && mag1 != '0));

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (rst)
    (done && err_cnt == 2'd2) |-> (loc1 < loc2 && mag1 != '0 && mag2 != '0));

  assert_eed_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (done && eed) |-> (err_cnt == 2'd0 && loc1 == '0 && loc2 == '0 && mag1 == '0));

  assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
    (done && err_cnt != 2'd0) |-> (loc1 <= P_LAST && loc2 <= P_LAST));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && syn_nz) |=> busy);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_irq_done_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    busy_cyc <= 32'(BUSY_MAX));

endmodule

bind twoerr_locator twoerr_locator_chk #(
  .SYM_W(SYM_W),
  .NPOS (NPOS),
  .POS_W(POS_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .syn0   (syn0),
  .syn1   (syn1),
  .syn2   (syn2),
  .syn3   (syn3),
  .busy   (busy),
  .done   (done),
  .irq    (irq),
  .err_cnt(err_cnt),
  .eed    (eed),
  .loc1   (loc1),
  .loc2   (loc2),
  .mag1   (mag1),
  .mag2   (mag2)
);

// File: tb/test_twoerr_locator.sv
module test_twoerr_locator;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 516;
  localparam int LAT_MAX    = 1548;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [9:0] syn0 = '0, syn1 = '0, syn2 = '0, syn3 = '0;
  logic       busy, done, irq, eed;
  logic [1:0] err_cnt;
  logic [9:0] loc1, loc2, mag1, mag2;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoerr_locator i_twoerr_locator (
    .clk(clk), .rst(rst), .start(start),
    .syn0(syn0), .syn1(syn1), .syn2(syn2), .syn3(syn3),
    .busy(busy), .done(done), .irq(irq), .err_cnt(err_cnt), .eed(eed),
    .loc1(loc1), .loc2(loc2), .mag1(mag1), .mag2(mag2)
  );

  // ---------- field arithmetic (x^10 + x^3 + 1) ----------
  function automatic logic [9:0] xt(input logic [9:0] a);
    return {a[8:0], 1'b0} ^ (a[9] ? 10'h009 : 10'h000);
  endfunction

  function automatic logic [9:0] gmul(input logic [9:0] a, input logic [9:0] b);
    logic [9:0] r = '0;
    logic [9:0] t = a;
    for (int i = 0; i < 10; i++) begin
      if (b[i]) r = r ^ t;
      t = xt(t);
    end
    return r;
  endfunction

  function automatic logic [9:0] apow(input int n);
    logic [9:0] r = 10'd1;
    for (int i = 0; i < (n % 1023); i++) r = xt(r);
    return r;
  endfunction

  // ---------- stimulus state ----------
  int         nerr;
  int         epos [3];
  logic [9:0] emag [3];
  logic [9:0] s [4];

  int         x_cnt, x_l1, x_l2;
  logic [9:0] x_m1, x_m2;
  bit         x_eed;

  int         lat;
  bit         busy_seen, irq_seen;
  int         a_cnt, a_l1, a_l2;
  logic [9:0] a_m1, a_m2;
  bit         a_eed;

  task automatic build_syn();
    for (int j = 0; j < 4; j++) begin
      s[j] = '0;
      for (int e = 0; e < nerr; e++) s[j] = s[j] ^ gmul(emag[e], apow(epos[e] * j));
    end
  endtask

  // expected result from injected 1 or 2 in-range errors
  task automatic expect_injected();
    x_eed = 0; x_cnt = nerr; x_l2 = 0; x_m2 = '0;
    if (nerr == 0) begin x_l1 = 0; x_m1 = '0; end
    else if (nerr == 1) begin x_l1 = epos[0]; x_m1 = emag[0]; end
    else if (epos[0] < epos[1]) begin
      x_l1 = epos[0]; x_m1 = emag[0]; x_l2 = epos[1]; x_m2 = emag[1];
    end else begin
      x_l1 = epos[1]; x_m1 = emag[1]; x_l2 = epos[0]; x_m2 = emag[0];
    end
  endtask

  // expected result from the decision rules for arbitrary syndromes
  task automatic expect_rules();
    logic [9:0] qa, qb, qc, x, d, n, r1x, r2x;
    int roots, r1, r2;
    x_cnt = 0; x_eed = 0; x_l1 = 0; x_l2 = 0; x_m1 = '0; x_m2 = '0;
    if ((s[0] | s[1] | s[2] | s[3]) == '0) return;
    qa = gmul(s[0], s[2]) ^ gmul(s[1], s[1]);
    qb = gmul(s[0], s[3]) ^ gmul(s[1], s[2]);
    qc = gmul(s[1], s[3]) ^ gmul(s[2], s[2]);
    x_eed = 1;
    if (qa == '0 && qc == '0 && s[0] != '0) begin
      x = 10'd1;
      for (int k = 0; k < NP; k++) begin
        if (gmul(s[0], x) == s[1]) begin
          x_eed = 0; x_cnt = 1; x_l1 = k; x_m1 = s[0];
          break;
        end
        x = xt(x);
      end
    end else if (qa != '0) begin
      roots = 0; r1 = 0; r2 = 0; r1x = '0; r2x = '0; x = 10'd1;
      for (int k = 0; k < NP; k++) begin
        if ((gmul(qa, gmul(x, x)) ^ gmul(qb, x) ^ qc) == '0) begin
          if (roots == 0) begin r1 = k; r1x = x; end
          else begin r2 = k; r2x = x; end
          roots++;
        end
        x = xt(x);
      end
      if (roots == 2) begin
        d = r1x ^ r2x;
        n = gmul(s[0], r2x) ^ s[1];
        for (int e = 1; e < 1024; e++) begin
          if (n != '0 && gmul(10'(e), d) == n && (s[0] ^ 10'(e)) != '0) begin
            x_eed = 0; x_cnt = 2; x_l1 = r1; x_l2 = r2;
            x_m1 = 10'(e); x_m2 = s[0] ^ 10'(e);
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive syndromes, pulse start, wait for done; optional mid-run disturbance
  task automatic run_dec(input bit disturb);
    @(negedge clk);
    syn0 = s[0]; syn1 = s[1]; syn2 = s[2]; syn3 = s[3];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy_seen = busy;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
      if (disturb && lat == 3) begin
        syn0 = 10'($urandom); syn1 = 10'($urandom);
        syn2 = 10'($urandom); syn3 = 10'($urandom);
        start = 1'b1;
      end else if (disturb && lat == 4) begin
        start = 1'b0;
      end
    end
    irq_seen = irq;
    a_cnt = int'(err_cnt); a_eed = eed;
    a_l1 = int'(loc1); a_l2 = int'(loc2); a_m1 = mag1; a_m2 = mag2;
  endtask

  task automatic compare_all(input string req);
    bit nz = (s[0] | s[1] | s[2] | s[3]) != '0;
    chk(req, "err_cnt", a_cnt, x_cnt);
    chk(req, "eed", int'(a_eed), int'(x_eed));
    chk(req, "loc1", a_l1, x_l1);
    chk(req, "loc2", a_l2, x_l2);
    chk(req, "mag1", int'(a_m1), int'(x_m1));
    chk(req, "mag2", int'(a_m2), int'(x_m2));
    chk("R8", "irq at done", int'(irq_seen), int'(nz));
    chk("R9", "latency bound", int'(lat <= LAT_MAX), 1);
    if (nz) begin
      chk("R7", "busy after start", int'(busy_seen), 1);
      chk("R7", "busy low at done", int'(busy), 0);
    end
  endtask

  task automatic pick_positions(input int n);
    nerr = n;
    for (int e = 0; e < n; e++) begin
      bit clash;
      do begin
        epos[e] = int'($urandom % NP);
        clash = 0;
        for (int f = 0; f < e; f++) if (epos[f] == epos[e]) clash = 1;
      end while (clash);
      emag[e] = 10'(($urandom % 1023) + 1);
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R7", "reset busy", int'(busy), 0);
    chk("R7", "reset done", int'(done), 0);
    chk("R8", "reset irq", int'(irq), 0);
    chk("R4", "reset eed", int'(eed), 0);
    chk("R1", "reset err_cnt", int'(err_cnt), 0);

    // R1: all-zero syndromes complete at once
    nerr = 0; build_syn(); expect_injected();
    run_dec(0);
    chk("R1", "zero latency", lat, 1);
    chk("R1", "zero busy never", int'(busy_seen), 0);
    compare_all("R1");

    // R2 boundaries: single error at first and last position
    nerr = 1; epos[0] = 0; emag[0] = 10'h3FF; build_syn(); expect_injected();
    run_dec(0); compare_all("R2");
    nerr = 1; epos[0] = 515; emag[0] = 10'h001; build_syn(); expect_injected();
    run_dec(0); compare_all("R2");

    // R3 boundaries: both ends; equal values make S0 zero
    nerr = 2; epos[0] = 515; emag[0] = 10'h155; epos[1] = 0; emag[1] = 10'h2AA;
    build_syn(); expect_injected(); run_dec(0); compare_all("R3");
    nerr = 2; epos[0] = 17; emag[0] = 10'h0C3; epos[1] = 400; emag[1] = 10'h0C3;
    build_syn(); expect_injected(); run_dec(0); compare_all("R3");

    // R5: single error placed beyond the last position
    nerr = 1; epos[0] = 700; emag[0] = 10'h05A; build_syn();
    x_cnt = 0; x_eed = 1; x_l1 = 0; x_l2 = 0; x_m1 = '0; x_m2 = '0;
    run_dec(0); compare_all("R5");

    // R5: two errors, one beyond range
    nerr = 2; epos[0] = 10; emag[0] = 10'h111; epos[1] = 900; emag[1] = 10'h0F0;
    build_syn(); x_cnt = 0; x_eed = 1; x_l1 = 0; x_l2 = 0; x_m1 = '0; x_m2 = '0;
    run_dec(0); compare_all("R5");

    // R4: only S3 nonzero fits neither hypothesis
    s[0] = '0; s[1] = '0; s[2] = '0; s[3] = 10'h123;
    x_cnt = 0; x_eed = 1; x_l1 = 0; x_l2 = 0; x_m1 = '0; x_m2 = '0;
    run_dec(0); compare_all("R4");

    // R6: syndrome inputs change and start pulses mid-decode
    nerr = 1; epos[0] = 300; emag[0] = 10'h0AB; build_syn(); expect_injected();
    run_dec(1); compare_all("R6");
    begin
      int extra = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      chk("R6", "start while busy ignored", extra, 0);
    end

    // random mix of 0..3 errors
    for (int t = 0; t < 40; t++) begin
      int n = int'($urandom % 4);
      pick_positions(n);
      build_syn();
      if (n <= 2) begin
        expect_injected();
        run_dec(0);
        compare_all(n == 0 ? "R1" : (n == 1 ? "R2" : "R3"));
      end else begin
        expect_rules();
        run_dec(0);
        compare_all("R4");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule